// File: doc/BRIEF.md
# Iambic Paddle Morse Keyer

This block turns two paddle contacts, one for short elements and one for long elements, into a single keying line whose on and off times are exact multiples of a unit interval. The unit interval comes from outside as a one-cycle clock enable, `unit_tick`, produced by whatever speed setting the surrounding design uses. All state changes happen on cycles where that enable is high, so every element starts on a unit boundary.

Holding the short paddle sends a steady stream of dots; holding the long paddle sends a steady stream of dashes. Squeezing both alternates the two element types, starting with a dot when the squeeze begins from rest. A brief touch of the short paddle while a dash is being sent is remembered and produces exactly one dot after that dash, after which the dash stream carries on. An element that has begun always runs to the end of its trailing space, whatever the paddles do meanwhile.

Top module: `morse_paddle_keyer`

## Requirements
- R1: While reset is asserted and while no paddle is requesting an element, `key_out` is 0.
- R2: A dot is `key_out` high for exactly 1 unit followed by `key_out` low for exactly 1 unit before any further element.
- R3: A dash is `key_out` high for exactly 3 units followed by `key_out` low for exactly 1 unit before any further element.
- R4: With only `dot_in` held, dots repeat back to back; with only `dash_in` held, dashes repeat back to back.
- R5: When both paddles are held starting from rest, the first element is a dot, and elements then alternate dot, dash, dot, dash for as long as both stay held.
- R6: With `dash_in` held, a press of `dot_in` during a dash causes exactly one dot after that dash's space, after which dashes resume.
- R7: A `dot_in` press during a dash (its mark or its space) is stored and sends one dot even if both paddles are released before the dash ends.
- R8: Once an element starts, its mark and its trailing one-unit space complete regardless of paddle activity.
- R9: `key_out` changes only on clock edges where `unit_tick` is high; inputs are sampled for a new element only at such edges.
- R10: Asserting `rst_n` low forces `key_out` to 0 at once, abandons any element in progress and clears any stored dot press.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| unit_tick | input | 1 | One-cycle enable marking each unit interval |
| dot_in | input | 1 | Short-element paddle, high while pressed |
| dash_in | input | 1 | Long-element paddle, high while pressed |
| key_out | output | 1 | Keying line, high during an element's mark |

## Verification
The bench steps the keyer one unit at a time and compares the keying line after each unit against hand-derived waveforms for dot streams, dash streams, squeezes from rest, a tap inside a dash stream and a tap followed by release of both paddles. A design that picked the dash first on a fresh squeeze, lost a dot tap once the paddle came up, sent the tapped dot twice or skipped the space after a dash would show a wrong bit in a specific unit of those waveforms. Between units the bench holds the enable low and checks that the line does not move, which catches a keyer that counts clock cycles instead of units. Reset is applied in the middle of a dash and right after a stored tap to catch an element or memory that survives reset.

// File: rtl/morse_paddle_keyer.sv
module morse_paddle_keyer #(
  parameter int DOT_UNITS  = 1,
  parameter int DASH_UNITS = 3,
  parameter int GAP_UNITS  = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic unit_tick,
  input  logic dot_in,
  input  logic dash_in,
  output logic key_out
);
  localparam int MAXU = (DASH_UNITS > GAP_UNITS) ? DASH_UNITS : GAP_UNITS;
  localparam int CW   = $clog2(MAXU + 1);

  typedef enum logic [1:0] {S_REST, S_MARK, S_SPACE} phase_t;

  phase_t        phase;
  logic [CW-1:0] units_left;
  logic          was_dash;
  logic          dot_held;

  wire last_unit = (units_left == CW'(1));
  wire dot_req   = dot_in | dot_held;
  wire any_req   = dot_req | dash_in;
  wire decide    = unit_tick & ((phase == S_REST) | ((phase == S_SPACE) & last_unit));
  wire pick_dash = (dot_req & dash_in) ? ((phase == S_SPACE) & ~was_dash) : dash_in;
  wire launch    = decide & any_req;

  assign key_out = (phase == S_MARK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= S_REST;
      units_left <= '0;
      was_dash   <= 1'b0;
    end else if (unit_tick) begin
      if (phase == S_MARK) begin
        if (last_unit) begin
          phase      <= S_SPACE;
          units_left <= CW'(GAP_UNITS);
        end else begin
          units_left <= units_left - CW'(1);
        end
      end else if (phase == S_SPACE && !last_unit) begin
        units_left <= units_left - CW'(1);
      end else if (launch) begin
        phase      <= S_MARK;
        was_dash   <= pick_dash;
        units_left <= pick_dash ? CW'(DASH_UNITS) : CW'(DOT_UNITS);
      end else begin
        phase <= S_REST;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      dot_held <= 1'b0;
    else if (launch && !pick_dash)
      dot_held <= 1'b0;
    else if (dot_in && was_dash && phase != S_REST)
      dot_held <= 1'b1;
  end
endmodule

// File: rtl/morse_paddle_keyer_chk.sv
module morse_paddle_keyer_chk #(
  parameter int DOT_UNITS  = 1,
  parameter int DASH_UNITS = 3
) (
  input logic clk,
  input logic rst_n,
  input logic unit_tick,
  input logic key_out
);
  logic [7:0] high_run;
  logic [7:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      high_run <= '0;
      low_run  <= '0;
    end else begin
      if (!key_out) high_run <= '0;
      else if (unit_tick && high_run != 8'hFF) high_run <= high_run + 8'd1;
      if (key_out) low_run <= '0;
      else if (unit_tick && low_run != 8'hFF) low_run <= low_run + 8'd1;
    end
  end

  always @(posedge clk)
    if (!rst_n) assert_quiet_in_reset_R1: assert (key_out == 1'b0);

  assert_mark_length_R2_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(key_out) |-> (high_run == 8'(DOT_UNITS) || high_run == 8'(DASH_UNITS)));

  assert_space_before_mark_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_out) |-> (low_run >= 8'd1));

  assert_hold_without_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !unit_tick |=> $stable(key_out));

  assert_rise_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_out) |-> $past(unit_tick));
endmodule

bind morse_paddle_keyer morse_paddle_keyer_chk #(
  .DOT_UNITS (DOT_UNITS),
  .DASH_UNITS(DASH_UNITS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .unit_tick(unit_tick),
  .key_out  (key_out)
);

// File: tb/tb_morse_paddle_keyer.sv
`timescale 1ns/1ps
module tb_morse_paddle_keyer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic unit_tick = 1'b0;
  logic dot_in = 1'b0;
  logic dash_in = 1'b0;
  logic key_out;

  int compared = 0;
  int mismatched = 0;

  always #2 clk = ~clk;

  morse_paddle_keyer dut (
    .clk(clk), .rst_n(rst_n), .unit_tick(unit_tick),
    .dot_in(dot_in), .dash_in(dash_in), .key_out(key_out)
  );

  // each entry: {dot_in, dash_in, expected key_out after that unit}
  localparam int NV = 43;
  localparam logic [2:0] VEC [NV] = '{
    // 0..5 dot stream (R2, R4)
    3'b101, 3'b100, 3'b101, 3'b100, 3'b000, 3'b000,
    // 6..14 dash stream, finishes after release (R3, R4, R8)
    3'b011, 3'b011, 3'b011, 3'b010, 3'b011, 3'b001, 3'b001, 3'b000, 3'b000,
    // 15..24 squeeze from rest, dot first (R5)
    3'b111, 3'b110, 3'b111, 3'b111, 3'b111, 3'b110, 3'b111, 3'b110, 3'b000, 3'b000,
    // 25..35 tap inside dash stream (R6)
    3'b011, 3'b111, 3'b011, 3'b010, 3'b011, 3'b010, 3'b011, 3'b011, 3'b011, 3'b010, 3'b000,
    // 36..42 tap then full release (R7)
    3'b011, 3'b101, 3'b001, 3'b000, 3'b001, 3'b000, 3'b000
  };

  function automatic string tag_of(int i);
    if (i < 6)  return "R2/R4";
    if (i < 15) return "R3/R8";
    if (i < 25) return "R5";
    if (i < 36) return "R6";
    return "R7";
  endfunction

  task automatic check(string req, logic act, logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: key_out=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic unit_step(input logic d, input logic a, output logic k);
    @(negedge clk);
    dot_in = d; dash_in = a; unit_tick = 1'b1;
    @(negedge clk);
    unit_tick = 1'b0;
    k = key_out;
  endtask

  initial begin
    logic k;
    repeat (3) @(negedge clk);
    check("R1", key_out, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    unit_step(1'b0, 1'b0, k);
    check("R1", k, 1'b0);

    for (int i = 0; i < NV; i++) begin
      unit_step(VEC[i][2], VEC[i][1], k);
      check(tag_of(i), k, VEC[i][0]);
      @(negedge clk);
      check("R9", key_out, k);
    end

    // R10: reset in the middle of a dash
    unit_step(1'b0, 1'b1, k);
    check("R3", k, 1'b1);
    #1 rst_n = 1'b0;
    #1 check("R10", key_out, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    unit_step(1'b0, 1'b0, k);
    check("R10", k, 1'b0);

    // R10: stored tap is cleared by reset
    unit_step(1'b0, 1'b1, k);
    unit_step(1'b1, 1'b0, k);
    @(negedge clk);
    dot_in = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    unit_step(1'b0, 1'b0, k);
    check("R10", k, 1'b0);
    unit_step(1'b0, 1'b0, k);
    check("R10", k, 1'b0);

    // R9: paddle held for many cycles without a tick leaves the line idle
    @(negedge clk);
    dot_in = 1'b1;
    repeat (10) @(negedge clk);
    check("R9", key_out, 1'b0);
    unit_step(1'b1, 1'b0, k);
    check("R2", k, 1'b1);
    unit_step(1'b0, 1'b0, k);
    check("R2", k, 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule